// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block pairs a parameterised adder/subtractor and bitwise logic unit with the status flags that describe its result. For each operation it computes the result word and six flags: carry (borrow when subtracting), signed overflow, sign, zero, half-carry between the low nibble and the next, and even parity of the low result byte. The result and the flag vector are combinational outputs.

A flag register captures the flag vector on any clock where the update enable is high. Two per-bit masks let software force individual flag bits to one or to zero. When a mask touches a bit in the same cycle as an update, the mask decides that bit. Opcodes: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR. Codes 5 to 7 are unused.

Top module: `aluflag_unit`

## Requirements
- R1: With opcode 0 the result is opnd_a + opnd_b + carry_in modulo 2^DATA_W. With opcode 1 it is opnd_a - opnd_b - carry_in modulo 2^DATA_W.
- R2: Opcodes 2, 3 and 4 give the bitwise AND, OR and XOR of the operands. Opcodes 5 to 7 give a result of zero and are handled like a logic operation.
- R3: Flag bit 0 (carry) is set when an add result exceeds 2^DATA_W-1, or when a subtract needs a borrow (opnd_b + carry_in > opnd_a, unsigned). It is clear for every non-arithmetic opcode.
- R4: Flag bit 5 (overflow) is set when the signed two's-complement result of an add or subtract lies outside the DATA_W-bit signed range. It is clear for every non-arithmetic opcode.
- R5: Flag bit 4 (sign) equals the result MSB. Flag bit 3 (zero) is set exactly when the result is all zeros.
- R6: Flag bit 2 (half-carry) is set on an add when the low nibbles plus carry_in exceed 15. It is set on a subtract when opnd_b[3:0] + carry_in > opnd_a[3:0]. It is clear for every non-arithmetic opcode.
- R7: Flag bit 1 (parity) is set when result[7:0] holds an even number of ones.
- R8: A rising clock edge with rst_n low clears the flag register to all zeros.
- R9: On a clock edge with upd_en high, the flag register loads flags_now. With upd_en low it holds its value, except for bits named by the masks.
- R10: A bit set in set_mask forces that register bit to 1. A bit set only in clr_mask forces it to 0. Both masks take priority over the update, and set_mask wins when both name the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 3 | Operation select |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| carry_in | input | 1 | Carry-in for add, borrow-in for subtract |
| upd_en | input | 1 | Load the flag register from flags_now |
| set_mask | input | 6 | Per-bit force-to-one write |
| clr_mask | input | 6 | Per-bit force-to-zero write |
| result | output | DATA_W | Operation result |
| flags_now | output | 6 | Flags of the current operation |
| flags_q | output | 6 | Registered flag vector |

## Verification
Assertions check on every cycle that logic opcodes leave carry, half-carry and overflow clear. They also check that zero and sign are never both set, and that overflow only occurs when the operand signs permit it. On the register side they check that masked bits land as forced, that an unmasked update loads the flag vector, and that the register holds when nothing writes it. Only the bench scenarios can show that the arithmetic values are right: results, borrow and half-borrow with a borrow-in, the range edges at 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, and parity over random results. These are compared against a wide-integer reference model.

// File: rtl/aluflag_pkg.sv
// Shared opcode encoding and flag bit positions for the flag generator.
package aluflag_pkg;
    localparam int FLAG_N = 6;
    localparam int FB_CF  = 0;
    localparam int FB_PF  = 1;
    localparam int FB_AF  = 2;
    localparam int FB_ZF  = 3;
    localparam int FB_SF  = 4;
    localparam int FB_OF  = 5;

    typedef enum logic [2:0] {
        OPC_ADD = 3'd0,
        OPC_SUB = 3'd1,
        OPC_AND = 3'd2,
        OPC_OR  = 3'd3,
        OPC_XOR = 3'd4
    } opc_e;
endpackage

// File: rtl/aluflag_core.sv
// Datapath: one adder serves add and subtract (subtract inverts b and the
// carry-in); logic ops bypass it. Emits raw carry, half-carry and overflow,
// already gated to zero for non-arithmetic opcodes.
// Assumes DATA_W >= 8.
module aluflag_core
    import aluflag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res,
    output logic              cy,
    output logic              half_cy,
    output logic              ovf
);
    localparam int NIB = 4;
    localparam int MSB = DATA_W - 1;

    logic              is_sub;
    logic              is_arith;
    logic [DATA_W-1:0] b_eff;
    logic              c_eff;
    logic [DATA_W:0]   sum;
    logic [NIB:0]      nib_sum;

    // Operand conditioning for the shared adder.
    always_comb begin
        is_sub   = (op_code == OPC_SUB);
        is_arith = (op_code == OPC_ADD) || is_sub;
        b_eff    = is_sub ? ~opnd_b : opnd_b;
        c_eff    = is_sub ? ~carry_in : carry_in;
    end

    // Full-width and low-nibble sums.
    always_comb begin
        sum     = {1'b0, opnd_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
        nib_sum = {1'b0, opnd_a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]}
                + {{NIB{1'b0}}, c_eff};
    end

    // Result select and arithmetic flag derivation.
    always_comb begin
        case (op_code)
            OPC_ADD, OPC_SUB: res = sum[DATA_W-1:0];
            OPC_AND:          res = opnd_a & opnd_b;
            OPC_OR:           res = opnd_a | opnd_b;
            OPC_XOR:          res = opnd_a ^ opnd_b;
            default:          res = '0;
        endcase
        cy      = is_arith & (sum[DATA_W] ^ is_sub);
        half_cy = is_arith & (nib_sum[NIB] ^ is_sub);
        ovf     = is_arith & (opnd_a[MSB] == b_eff[MSB])
                           & (sum[MSB] != opnd_a[MSB]);
    end
endmodule

// File: rtl/aluflag_eval.sv
// Packs the six flags from the result word and the datapath's raw flags.
// Parity covers only the low PAR_W result bits.
module aluflag_eval
    import aluflag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PAR_W  = 8
) (
    input  logic [DATA_W-1:0] res,
    input  logic              cy,
    input  logic              half_cy,
    input  logic              ovf,
    output logic [FLAG_N-1:0] flags
);
    // Assemble the flag vector in its fixed bit order.
    always_comb begin
        flags         = '0;
        flags[FB_CF]  = cy;
        flags[FB_PF]  = ~(^res[PAR_W-1:0]);
        flags[FB_AF]  = half_cy;
        flags[FB_ZF]  = (res == '0);
        flags[FB_SF]  = res[DATA_W-1];
        flags[FB_OF]  = ovf;
    end
endmodule

// File: rtl/aluflag_freg.sv
// Flag register: optional load of the computed flags, then per-bit
// force-to-one / force-to-zero masks applied on top (set beats clear).
module aluflag_freg
    import aluflag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [FLAG_N-1:0] alu_flags,
    input  logic [FLAG_N-1:0] set_mask,
    input  logic [FLAG_N-1:0] clr_mask,
    output logic [FLAG_N-1:0] q
);
    logic [FLAG_N-1:0] base;

    // Choose between update and hold before masks.
    always_comb base = upd_en ? alu_flags : q;

    // Register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (base & ~clr_mask) | set_mask;
    end

    // R10: forced-one bits land as ones
    p_set_forces_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & $past(set_mask)) == $past(set_mask)));
    // R10: clear-only bits land as zeros
    p_clr_forces_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & $past(clr_mask) & ~$past(set_mask)) == '0));
    // R9: unmasked update loads the flags
    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && set_mask == '0 && clr_mask == '0) |=> (q == $past(alu_flags)));
    // R9: no writer means hold
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && set_mask == '0 && clr_mask == '0) |=> $stable(q));
endmodule

// File: rtl/aluflag_unit.sv
// Top: datapath, flag packing and the flag register. Assumes DATA_W >= 8.
module aluflag_unit
    import aluflag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_in,
    input  logic              upd_en,
    input  logic [5:0]        set_mask,
    input  logic [5:0]        clr_mask,
    output logic [DATA_W-1:0] result,
    output logic [5:0]        flags_now,
    output logic [5:0]        flags_q
);
    logic cy_w;
    logic hc_w;
    logic ov_w;

    aluflag_core #(.DATA_W(DATA_W)) u_core (
        .op_code  (op_code),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .carry_in (carry_in),
        .res      (result),
        .cy       (cy_w),
        .half_cy  (hc_w),
        .ovf      (ov_w)
    );

    aluflag_eval #(.DATA_W(DATA_W), .PAR_W(8)) u_eval (
        .res     (result),
        .cy      (cy_w),
        .half_cy (hc_w),
        .ovf     (ov_w),
        .flags   (flags_now)
    );

    aluflag_freg u_freg (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (upd_en),
        .alu_flags (flags_now),
        .set_mask  (set_mask),
        .clr_mask  (clr_mask),
        .q         (flags_q)
    );

    // R3, R4, R6: non-arithmetic opcodes raise no carry, half-carry or overflow
    p_logic_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code > 3'd1) |->
        (!flags_now[FB_CF] && !flags_now[FB_AF] && !flags_now[FB_OF]));
    // R5: a zero result is never negative
    p_zero_not_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flags_now[FB_ZF] |-> !flags_now[FB_SF]);
    // R4: add overflow needs equal operand signs
    p_add_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd0 && flags_now[FB_OF]) |->
        (opnd_a[DATA_W-1] == opnd_b[DATA_W-1]));
    // R4: subtract overflow needs differing operand signs
    p_sub_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd1 && flags_now[FB_OF]) |->
        (opnd_a[DATA_W-1] != opnd_b[DATA_W-1]));
endmodule

// File: tb/aluflag_unit_bench.sv
`timescale 1ns/1ps
module aluflag_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op_code;
    logic [31:0] opnd_a, opnd_b;
    logic        carry_in, upd_en;
    logic [5:0]  set_mask, clr_mask;
    logic [31:0] result;
    logic [5:0]  flags_now, flags_q;

    int checks = 0;
    int errors = 0;
    logic [5:0] exp_q;

    always #10 clk = ~clk;

    aluflag_unit #(.DATA_W(32)) u_aluflag_unit (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .carry_in(carry_in), .upd_en(upd_en),
        .set_mask(set_mask), .clr_mask(clr_mask), .result(result),
        .flags_now(flags_now), .flags_q(flags_q)
    );

    // Reference: {result, OF, SF, ZF, AF, PF, CF} from wide integer math.
    function automatic logic [37:0] ref_op(logic [2:0] op, logic [31:0] a,
                                           logic [31:0] b, logic ci);
        longint unsigned ua = 64'(a);
        longint unsigned ub = 64'(b);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint unsigned full;
        longint ss;
        logic [31:0] r;
        logic cf, of, af;
        cf = 0; of = 0; af = 0;
        case (op)
            3'd0: begin
                full = ua + ub + 64'(ci); r = full[31:0];
                cf = full > 64'hFFFF_FFFF;
                ss = sa + sb + 64'(ci);
                of = (ss > 64'sh7FFF_FFFF) || (ss < -64'sh8000_0000);
                af = ((ua & 15) + (ub & 15) + 64'(ci)) > 15;
            end
            3'd1: begin
                full = ua - ub - 64'(ci); r = full[31:0];
                cf = ua < (ub + 64'(ci));
                ss = sa - sb - 64'(ci);
                of = (ss > 64'sh7FFF_FFFF) || (ss < -64'sh8000_0000);
                af = (ua & 15) < ((ub & 15) + 64'(ci));
            end
            3'd2: r = a & b;
            3'd3: r = a | b;
            3'd4: r = a ^ b;
            default: r = 32'd0;
        endcase
        return {r, of, r[31], (r == 32'd0), af,
                ($countones(r[7:0]) % 2 == 0), cf};
    endfunction

    task automatic check6(string tag, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    // One operation: drive at negedge, check combinational outputs, then the register.
    task automatic do_op(logic [2:0] op, logic [31:0] a, logic [31:0] b,
                         logic ci, logic upd, logic [5:0] sm, logic [5:0] cm);
        logic [37:0] e;
        logic [5:0] nb;
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; carry_in = ci;
        upd_en = upd; set_mask = sm; clr_mask = cm;
        #2;
        e = ref_op(op, a, b, ci);
        checks++;
        if (result !== e[37:6]) begin
            errors++;
            $display("FAIL R1/R2 op %0d actual %h expected %h", op, result, e[37:6]);
        end
        check6("R3-flag R4 R5 R6 R7 flags_now", flags_now, e[5:0]);
        nb = upd ? e[5:0] : exp_q;
        exp_q = (nb & ~cm) | sm;
        @(posedge clk); #1;
        check6("R9/R10 flags_q", flags_q, exp_q);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd12345;
        void'($urandom(seed));
        rst_n = 0; op_code = 0; opnd_a = 0; opnd_b = 0; carry_in = 0;
        upd_en = 1; set_mask = 6'h3F; clr_mask = 0;
        repeat (2) @(posedge clk);
        #1;
        check6("R8 reset", flags_q, 6'h00);
        exp_q = 6'h00;
        @(negedge clk); rst_n = 1;

        // R1/R3/R4/R6 add edges
        do_op(3'd0, 32'h7FFF_FFFF, 32'h1, 0, 1, 0, 0);
        do_op(3'd0, 32'hFFFF_FFFF, 32'h1, 0, 1, 0, 0);
        do_op(3'd0, 32'hFFFF_FFFF, 32'h0, 1, 1, 0, 0);
        do_op(3'd0, 32'h8000_0000, 32'h8000_0000, 0, 1, 0, 0);
        // R1/R3/R6 subtract borrow, with borrow-in
        do_op(3'd1, 32'h0, 32'h1, 0, 1, 0, 0);
        do_op(3'd1, 32'h8000_0000, 32'h1, 0, 1, 0, 0);
        do_op(3'd1, 32'h10, 32'h0F, 1, 1, 0, 0);
        do_op(3'd1, 32'h5, 32'h5, 1, 1, 0, 0);
        do_op(3'd1, 32'h5, 32'h5, 0, 1, 0, 0);
        // R2/R5/R7 logic ops and unused codes
        do_op(3'd2, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1, 1, 0, 0);
        do_op(3'd4, 32'h0000_0001, 32'h0, 0, 1, 0, 0);
        do_op(3'd3, 32'h8000_0003, 32'h0, 0, 1, 0, 0);
        do_op(3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 0, 0);
        // R9 hold, R10 masks with and without update, set beats clear
        do_op(3'd0, 32'h1, 32'h1, 0, 0, 0, 0);
        do_op(3'd0, 32'hFFFF_FFFF, 32'h1, 0, 1, 6'h20, 6'h01);
        do_op(3'd2, 32'h0, 32'h0, 0, 0, 6'h05, 6'h05);
        do_op(3'd2, 32'h0, 32'h0, 0, 0, 6'h00, 6'h3F);
        do_op(3'd2, 32'h0, 32'h0, 0, 1, 6'h00, 6'h08);

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [2:0] op;
            logic [5:0] sm, cm;
            op = ($urandom % 8 < 6) ? 3'($urandom % 5) : 3'($urandom % 8);
            sm = ($urandom % 4 == 0) ? 6'($urandom) : 6'h0;
            cm = ($urandom % 4 == 0) ? 6'($urandom) : 6'h0;
            do_op(op, $urandom, ($urandom % 8 == 0) ? 32'($urandom % 16) : $urandom,
                  1'($urandom), 1'($urandom), sm, cm);
        end

        // R8 reset mid-run clears the register
        @(negedge clk); rst_n = 0; upd_en = 1; set_mask = 6'h3F;
        @(posedge clk); #1;
        check6("R8 reset mid-run", flags_q, 6'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule